// File: doc/BRIEF.md
# Leveled Interrupt Request Queue

This block stores interrupt requests that are waiting for service, split into eight priority levels. Each level holds a set of 8-bit vector numbers: one vector is either pending at a level or not, so posting it again changes nothing. Devices post a request by pulsing a write strobe together with a 3-bit level and an 8-bit vector.

Before each instruction the processor core pulses a check strobe and presents its 16-bit status word. The running priority sits in bits 7:5 of that word. The block chooses at most one pending request and clears it. In the next cycle it raises a one-cycle take pulse, with the chosen vector and its level alongside. The trap logic uses that level as the new running priority.

The level is chosen by an eligibility window. When the running priority is 3 or lower, every level from 0 upward is eligible. Otherwise only the levels above the running priority are eligible. Eligible levels are searched in ascending order. Within the winning level, the smallest pending vector is taken.

The control is a two-state machine:
- ST_IDLE: no take is being presented.
- ST_TAKE: the take pulse is high for one cycle.

A check that finds an eligible request moves the machine to ST_TAKE, from either state. A check that finds none, or a cycle with no check, moves it to ST_IDLE.

Top module: `lirq_queue`

## Requirements
- R1: A synchronous active-high reset clears every pending request. After reset, `take_o` is 0, and a check finds nothing until a new post arrives.
- R2: A post with `post_en_i`=1 makes vector `post_vec_i` pending at level `post_lvl_i` (0..7). Posting a vector that is already pending at that level has no further effect: it is taken only once.
- R3: Let P be the running priority. If P is 3 or lower, levels 0..7 are eligible. Otherwise only levels P+1..7 are eligible. With P = 7, no check ever takes anything.
- R4: Among the eligible levels that hold a pending vector, the lowest-numbered level wins. Each check takes at most one request.
- R5: Within the winning level, the numerically smallest pending vector is taken.
- R6: A taken vector is removed from its level, so a later check does not take it again.
- R7: `take_o` is high for exactly the one cycle after a check that found an eligible request. In that cycle `take_vec_o` and `take_lvl_o` hold the taken vector and its level. After a check that finds nothing eligible, and in cycles without a check, `take_o` stays low.
- R8: If a post and a take hit the same level and vector in the same cycle, the post wins. The take is still reported, and the entry stays pending.
- R9: A check looks only at requests posted in earlier cycles. A post made in the same cycle as the check is first seen by the next check.
- R10: The running priority is read only from bits 7:5 of `stat_word_i`. All other bits of the status word have no effect on which request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| post_en_i | input | 1 | Post strobe |
| post_lvl_i | input | 3 | Level of the posted request |
| post_vec_i | input | 8 | Vector of the posted request |
| chk_i | input | 1 | Check strobe from the core |
| stat_word_i | input | 16 | Status word; bits 7:5 hold the running priority |
| take_o | output | 1 | One-cycle pulse: a request was taken |
| take_vec_o | output | 8 | Vector of the taken request |
| take_lvl_o | output | 3 | Level of the taken request |

## Verification
The embedded properties check the following on every cycle:
- a take pulse only ever follows a check;
- the level taken lies inside the eligibility window of the priority that came with that check;
- a running priority of 7 never yields a take;
- a post leaves its entry pending;
- a taken entry is gone afterwards, unless a post hit it in the same cycle.

Some behaviours can only be shown by the bench's scenarios against its own model of the eight sets:
- which level and which vector win when several are pending;
- that duplicate posts collapse to a single entry;
- that the post wins over the take;
- that a same-cycle post stays invisible to that check;
- that the bits of the status word outside 7:5 are ignored.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } take_state_e;

endpackage

// File: rtl/lirq_lowest_find.sv
module lirq_lowest_find #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Walk from the top down so the lowest set bit is the last one written.
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lirq_store.sv
module lirq_store #(
    parameter int LEVELS = 8,
    parameter int VEC_W  = 8,
    parameter int LW     = $clog2(LEVELS),
    parameter int NVEC   = 1 << VEC_W
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          post_en_i,
    input  logic [LW-1:0]                 post_lvl_i,
    input  logic [VEC_W-1:0]              post_vec_i,
    input  logic                          clr_en_i,
    input  logic [LW-1:0]                 clr_lvl_i,
    input  logic [VEC_W-1:0]              clr_vec_i,
    output logic [LEVELS-1:0][NVEC-1:0]   pend_o
);

    logic [NVEC-1:0] set_onehot;
    logic [NVEC-1:0] clr_onehot;

    assign set_onehot = NVEC'(1) << post_vec_i;
    assign clr_onehot = NVEC'(1) << clr_vec_i;

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        logic [NVEC-1:0] set_m;
        logic [NVEC-1:0] clr_m;

        assign set_m = (post_en_i && (post_lvl_i == LW'(g))) ? set_onehot : '0;
        assign clr_m = (clr_en_i  && (clr_lvl_i  == LW'(g))) ? clr_onehot : '0;

        // The set is applied after the clear, so a post to the same entry wins.
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pend_o[g] <= '0;
            end else begin
                pend_o[g] <= (pend_o[g] & ~clr_m) | set_m;
            end
        end
    end

    AST_POST_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
        post_en_i |=> pend_o[$past(post_lvl_i)][$past(post_vec_i)]); // R2

endmodule

// File: rtl/lirq_level_pick.sv
module lirq_level_pick #(
    parameter int LEVELS   = 8,
    parameter int OPEN_MAX = 3,
    parameter int LW       = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] busy_i,
    input  logic [LW-1:0]     pri_i,
    output logic              hit_o,
    output logic [LW-1:0]     lvl_o
);

    logic [LW:0]         start_lvl;
    logic [LEVELS-1:0]   elig;

    // At or below the open threshold every level may interrupt; above it,
    // only the levels strictly higher than the running priority.
    always_comb begin
        if ({1'b0, pri_i} <= (LW+1)'(OPEN_MAX)) begin
            start_lvl = '0;
        end else begin
            start_lvl = {1'b0, pri_i} + (LW+1)'(1);
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_elig
        assign elig[g] = busy_i[g] & ((LW+1)'(g) >= start_lvl);
    end

    lirq_lowest_find #(
        .W  (LEVELS),
        .IW (LW)
    ) u_lvl_find (
        .vec_i   (elig),
        .found_o (hit_o),
        .idx_o   (lvl_o)
    );

endmodule

// File: rtl/lirq_queue.sv
module lirq_queue #(
    parameter int LEVELS   = 8,
    parameter int VEC_W    = 8,
    parameter int STAT_W   = 16,
    parameter int PRI_LSB  = 5,
    parameter int OPEN_MAX = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              post_en_i,
    input  logic [2:0]        post_lvl_i,
    input  logic [VEC_W-1:0]  post_vec_i,
    input  logic              chk_i,
    input  logic [STAT_W-1:0] stat_word_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  take_vec_o,
    output logic [2:0]        take_lvl_o
);

    import lirq_pkg::*;

    localparam int LW   = $clog2(LEVELS);
    localparam int NVEC = 1 << VEC_W;

    logic [LEVELS-1:0][NVEC-1:0] pend;
    logic [LEVELS-1:0]           busy;
    logic [LW-1:0]               pri;
    logic                        lvl_hit;
    logic [LW-1:0]               sel_lvl;
    logic [NVEC-1:0]             sel_row;
    logic                        vec_hit;
    logic [VEC_W-1:0]            sel_vec;
    logic                        grant;

    take_state_e       state_q, state_d;
    logic [VEC_W-1:0]  vec_q;
    logic [LW-1:0]     lvl_q;

    assign pri = stat_word_i[PRI_LSB +: LW];

    for (genvar g = 0; g < LEVELS; g++) begin : g_busy
        assign busy[g] = |pend[g];
    end

    lirq_store #(
        .LEVELS (LEVELS),
        .VEC_W  (VEC_W),
        .LW     (LW),
        .NVEC   (NVEC)
    ) u_store (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .post_en_i  (post_en_i),
        .post_lvl_i (post_lvl_i[LW-1:0]),
        .post_vec_i (post_vec_i),
        .clr_en_i   (grant),
        .clr_lvl_i  (sel_lvl),
        .clr_vec_i  (sel_vec),
        .pend_o     (pend)
    );

    lirq_level_pick #(
        .LEVELS   (LEVELS),
        .OPEN_MAX (OPEN_MAX),
        .LW       (LW)
    ) u_pick (
        .busy_i (busy),
        .pri_i  (pri),
        .hit_o  (lvl_hit),
        .lvl_o  (sel_lvl)
    );

    assign sel_row = pend[sel_lvl];

    lirq_lowest_find #(
        .W  (NVEC),
        .IW (VEC_W)
    ) u_vec_find (
        .vec_i   (sel_row),
        .found_o (vec_hit),
        .idx_o   (sel_vec)
    );

    assign grant = chk_i & lvl_hit & vec_hit;

    // Next-state decision.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = grant ? ST_TAKE : ST_IDLE;
            ST_TAKE: state_d = grant ? ST_TAKE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with the captured take data.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            if (grant) begin
                vec_q <= sel_vec;
                lvl_q <= sel_lvl;
            end
        end
    end

    // Outputs.
    always_comb begin
        take_o     = (state_q == ST_TAKE);
        take_vec_o = vec_q;
        take_lvl_o = 3'(lvl_q);
    end

    AST_TAKE_AFTER_CHECK: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> $past(chk_i)); // R7

    AST_TAKE_ELIGIBLE: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> (($past(pri) <= LW'(OPEN_MAX)) || (lvl_q > $past(pri)))); // R3

    AST_TOP_PRI_MUTE: assert property (@(posedge clk_i) disable iff (rst_i)
        (chk_i && (pri == LW'(LEVELS - 1))) |=> !take_o); // R3

    AST_TAKEN_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_o && !($past(post_en_i) && ($past(post_lvl_i[LW-1:0]) == lvl_q)
                     && ($past(post_vec_i) == vec_q)))
        |-> !pend[lvl_q][vec_q]); // R6

endmodule

// File: tb/lirq_queue_tb.sv
`timescale 1ns/1ps
module lirq_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        post_en;
    logic [2:0]  post_lvl;
    logic [7:0]  post_vec;
    logic        chk;
    logic [15:0] stat_word;
    logic        take;
    logic [7:0]  take_vec;
    logic [2:0]  take_lvl;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  model [8][256];

    always #2.5 clk = ~clk;

    lirq_queue dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .post_en_i   (post_en),
        .post_lvl_i  (post_lvl),
        .post_vec_i  (post_vec),
        .chk_i       (chk),
        .stat_word_i (stat_word),
        .take_o      (take),
        .take_vec_o  (take_vec),
        .take_lvl_o  (take_lvl)
    );

    function automatic bit [15:0] sw_of(input int p);
        return 16'(p << 5);
    endfunction

    task automatic expect_pick(input bit [15:0] sw, output bit hit,
                               output int lv, output int vc);
        int p;
        int s;
        p = int'(sw[7:5]);
        s = (p <= 3) ? 0 : p + 1;
        hit = 1'b0; lv = 0; vc = 0;
        for (int l = s; l < 8 && !hit; l++) begin
            for (int v = 0; v < 256 && !hit; v++) begin
                if (model[l][v]) begin
                    hit = 1'b1; lv = l; vc = v;
                end
            end
        end
    endtask

    task automatic cmp(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Starts and ends at a falling edge.
    task automatic step(input bit pe, input int pl, input int pv,
                        input bit ck, input bit [15:0] sw, input string tag);
        bit eh; int el; int ev;
        post_en = pe; post_lvl = 3'(pl); post_vec = 8'(pv);
        chk = ck; stat_word = sw;
        eh = 1'b0; el = 0; ev = 0;
        if (ck) expect_pick(sw, eh, el, ev);
        @(posedge clk);
        if (eh) model[el][ev] = 1'b0;
        if (pe) model[pl][pv] = 1'b1;
        @(negedge clk);
        post_en = 1'b0; chk = 1'b0;
        cmp(tag, int'(take), int'(eh), "take");
        if (eh) begin
            cmp(tag, int'(take_vec), ev, "vector");
            cmp(tag, int'(take_lvl), el, "level");
        end
    endtask

    task automatic post(input int l, input int v, input string tag);
        step(1'b1, l, v, 1'b0, 16'h0, tag);
    endtask

    task automatic check(input bit [15:0] sw, input string tag);
        step(1'b0, 0, 0, 1'b1, sw, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; post_en = 1'b0; chk = 1'b0;
        post_lvl = '0; post_vec = '0; stat_word = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < 8; l++)
            for (int v = 0; v < 256; v++) model[l][v] = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 20; i++) check(sw_of(0), tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        cmp("R1", int'(take), 0, "take after reset");

        // R1: pending entries are lost on reset
        post(2, 8'h33, "R1"); post(6, 8'h07, "R1");
        do_reset();
        check(sw_of(0), "R1");

        // R2: a duplicate post keeps a single entry
        post(2, 8'h40, "R2"); post(2, 8'h40, "R2");
        check(sw_of(0), "R2"); check(sw_of(0), "R2");

        // R3: eligibility window
        post(2, 8'h10, "R3"); post(4, 8'h20, "R3"); post(5, 8'h30, "R3"); post(7, 8'h70, "R3");
        check(sw_of(3), "R3");   // level 2
        check(sw_of(4), "R3");   // level 5, skips 4
        check(sw_of(7), "R3");   // nothing
        check(sw_of(6), "R3");   // level 7
        check(sw_of(5), "R3");   // nothing above 5 left
        // R4: the lowest eligible level wins
        check(sw_of(1), "R4");   // level 4
        post(6, 8'h01, "R4"); post(1, 8'hF0, "R4");
        check(sw_of(0), "R4"); check(sw_of(0), "R4");

        // R5: smallest vector inside a level
        post(1, 8'h90, "R5"); post(1, 8'h11, "R5"); post(1, 8'hFE, "R5");
        check(sw_of(2), "R5"); check(sw_of(2), "R5"); check(sw_of(2), "R5");
        // R6: the level is now empty
        check(sw_of(2), "R6");

        // R8: a post on the entry being taken wins
        post(1, 8'h05, "R8");
        step(1'b1, 1, 8'h05, 1'b1, sw_of(0), "R8");
        check(sw_of(0), "R8"); check(sw_of(0), "R8");

        // R9: a same-cycle post is not seen by that check
        step(1'b1, 3, 8'h22, 1'b1, sw_of(0), "R9");
        check(sw_of(0), "R9");

        // R10: only bits 7:5 carry the priority
        post(2, 8'h44, "R10");
        check(16'hFF1F, "R10");  // priority 0, level 2 taken
        post(2, 8'h45, "R10");
        check(16'h00E0, "R10");  // priority 7, nothing
        check(16'h1F5F, "R10");  // priority 2, taken
        drain("R6");

        // Random traffic with a narrow vector range to provoke collisions
        for (int i = 0; i < 3000; i++) begin
            bit pe; bit ck;
            pe = ($urandom % 3) != 0;
            ck = ($urandom % 2) != 0;
            step(pe, int'($urandom % 8), int'($urandom % 12), ck,
                 16'($urandom), "R4");
        end
        drain("R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule